// File: doc/BRIEF.md
# General-purpose I/O controller with level and edge interrupts

This block controls up to 32 general-purpose pins from a small 32-bit register bus. Each pin can be lent to an alternate-function path, which then drives the pad directly. Otherwise the pin's direction, output enable and output level come from registers. Every pad input goes through a two-flop synchroniser, and the synchronised value can be read back.

Each pin has its own interrupt detector. A detector can be set to a high or low level, a rising or falling edge, or both edges. Detected events collect in a pending register. Reading that register returns the pending bits and clears them in the same access, so there is no separate acknowledge. A mask register can only be changed through two write-one strobes, one that unmasks and one that masks. A single interrupt line is high whenever a pending bit is unmasked.

Bus accesses complete in one cycle. `bus_rdata` is valid combinationally in any cycle where `bus_en` is high and `bus_we` is low. Writes take effect at the clock edge.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every pin reads as an input, and the mask reads all ones. Bypass, output enable, output value, pending, type, polarity and both-edge registers all read zero.
- R2: Register bits at or above `NPIN` read as zero, and writes to those bits have no effect.
- R3: When bypass is off, a pin drives its pad (`pad_oe`=1) only if its direction bit is 0 (output) and its output-enable bit is 1. For a pin whose direction bit is 1, the output-enable bit has no effect.
- R4: A bypass bit of 1 (register at 0x00) connects `alt_out`/`alt_oe` to the pad for that pin. A bypass bit of 0 connects the register-controlled path.
- R5: The output-value register at 0x0C reads back the last value written. While bypass is off, it is the level on `pad_out`.
- R6: The input register at 0x10 shows `pad_in` after exactly two clock edges of synchronisation.
- R7: A 1 written to 0x18 clears that pin's mask bit, and a 1 written to 0x1C sets it. Zero bits leave the mask unchanged. The mask is read at 0x14, and writes to 0x14 are ignored.
- R8: Reading the pending register at 0x20 returns the pending bits and clears them at the end of that access.
- R9: When a pin's type bit (0x24) is 1, the pin is level-sensitive. Its polarity bit (0x28) selects the active level: 1 means high, 0 means low. While the level stays active, the pending bit is set again on the cycle after a clearing read.
- R10: When the type bit is 0 and the both-edge bit (0x2C) is 0, the polarity bit selects the edge: 1 means rising, 0 means falling.
- R11: When the type bit is 0 and the both-edge bit is 1, either edge sets the pending bit.
- R12: `irq` is high exactly when some pending bit has a mask bit of 0.
- R13: Pending bits are set even while masked. They stay set until the pending register is read.
- R14: The register map uses byte offsets. Direction is at 0x04 and output enable at 0x08. Reads from offsets not listed read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| pad_in | input | NPIN | Raw pad levels, asynchronous |
| pad_out | output | NPIN | Level to drive on each pad |
| pad_oe | output | NPIN | Pad driver enable per pin |
| alt_out | input | NPIN | Alternate-function output level |
| alt_oe | input | NPIN | Alternate-function driver enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus performs at most one access per cycle, and that `bus_addr` and `bus_wdata` are stable while `bus_en` is high. The bench keeps to this by driving one complete access per cycle, changing the bus signals only on the falling clock edge. The assertions also assume that `pad_in` changes only between clock edges, so the synchroniser sees clean values. The bench meets this by changing pad levels only on the falling clock edge.

// File: rtl/gpio_pkg.sv
// gpio_pkg: register offsets and bus widths shared by the GPIO controller.
// Assumes byte addressing with 32-bit registers on word boundaries.
package gpio_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_BYPASS = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_OE     = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IN     = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_SETMSK = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_TYPE   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_POL    = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 6'h2C;
endpackage

// File: rtl/gpio_sync.sv
// gpio_sync: two-flop synchroniser, one per pin.
// Assumes every bit of din is independent; no bus coherency is provided.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;

    // capture the raw level, then re-register it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end

    // R6
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_irq.sv
// gpio_irq: per-pin event detection and the clear-on-read pending register.
// Assumes din is already synchronised. clr is a one-cycle read strobe.
module gpio_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] lvl_sel,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] both,
    input  logic         clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] prev_q;
    logic [W-1:0] evt;

    // previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // per-pin event selection from the type, polarity and both-edge bits
    for (genvar i = 0; i < W; i++) begin : g_det
        always_comb begin
            if (lvl_sel[i])   evt[i] = ~(din[i] ^ pol[i]);
            else if (both[i]) evt[i] = din[i] ^ prev_q[i];
            else if (pol[i])  evt[i] = din[i] & ~prev_q[i];
            else              evt[i] = ~din[i] & prev_q[i];
        end
    end

    // pending bits: accumulate events; a read clears them, same-cycle events survive
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (clr ? '0 : pend) | evt;
    end

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((pend & ~$past(evt)) == '0));
    // R13
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(pend) & ~pend) == '0));
endmodule

// File: rtl/gpio_padmux.sv
// gpio_padmux: per-pin choice between the register path and the alternate path.
// Assumes a direction bit of 1 means input, in which case the pad is not driven.
module gpio_padmux #(
    parameter int W = 32
) (
    input  logic [W-1:0] byp,
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] outv,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        // select output level and driver enable for one pin
        always_comb begin
            if (byp[i]) begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
            end else begin
                pad_out[i] = outv[i];
                pad_oe[i]  = oe[i] & ~dir_in[i];
            end
        end
    end
endmodule

// File: rtl/gpio_ctrl.sv
// gpio_ctrl: GPIO controller top. It holds the register file and instantiates the
// synchroniser, interrupt detector and pad mux.
// Assumes one bus access per cycle with single-cycle completion, and NPIN <= 32.
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    input  logic [NPIN-1:0]   alt_out,
    input  logic [NPIN-1:0]   alt_oe,
    output logic              irq
);
    localparam logic [NPIN-1:0] ALL1 = {NPIN{1'b1}};

    logic [NPIN-1:0] byp_q, dir_q, oe_q, out_q, mask_q, type_q, pol_q, both_q;
    logic [NPIN-1:0] in_s, pend;
    logic [NPIN-1:0] wd;
    logic            wr, rd, pend_clr;

    assign wr       = bus_en & bus_we;
    assign rd       = bus_en & ~bus_we;
    assign wd       = bus_wdata[NPIN-1:0];
    assign pend_clr = rd && (bus_addr == OFS_PEND);

    if (NPIN < DATA_W) begin : g_unused
        logic unused_hi;
        assign unused_hi = ^bus_wdata[DATA_W-1:NPIN];
    end

    // plain read/write configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q  <= '0;
            dir_q  <= ALL1;
            oe_q   <= '0;
            out_q  <= '0;
            type_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr) begin
            case (bus_addr)
                OFS_BYPASS: byp_q  <= wd;
                OFS_DIR:    dir_q  <= wd;
                OFS_OE:     oe_q   <= wd;
                OFS_OUT:    out_q  <= wd;
                OFS_TYPE:   type_q <= wd;
                OFS_POL:    pol_q  <= wd;
                OFS_BOTH:   both_q <= wd;
                default: ;
            endcase
        end
    end

    // mask register, changed only through the unmask and mask strobes
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= ALL1;
        else if (wr && bus_addr == OFS_UNMASK) mask_q <= mask_q & ~wd;
        else if (wr && bus_addr == OFS_SETMSK) mask_q <= mask_q | wd;
    end

    // read mux; values are zero-extended, and unlisted offsets read zero
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                OFS_BYPASS: bus_rdata = DATA_W'(byp_q);
                OFS_DIR:    bus_rdata = DATA_W'(dir_q);
                OFS_OE:     bus_rdata = DATA_W'(oe_q);
                OFS_OUT:    bus_rdata = DATA_W'(out_q);
                OFS_IN:     bus_rdata = DATA_W'(in_s);
                OFS_MASK:   bus_rdata = DATA_W'(mask_q);
                OFS_PEND:   bus_rdata = DATA_W'(pend);
                OFS_TYPE:   bus_rdata = DATA_W'(type_q);
                OFS_POL:    bus_rdata = DATA_W'(pol_q);
                OFS_BOTH:   bus_rdata = DATA_W'(both_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    gpio_sync #(.W(NPIN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_s)
    );

    gpio_irq #(.W(NPIN)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (in_s),
        .lvl_sel(type_q),
        .pol    (pol_q),
        .both   (both_q),
        .clr    (pend_clr),
        .pend   (pend)
    );

    gpio_padmux #(.W(NPIN)) u_mux (
        .byp    (byp_q),
        .dir_in (dir_q),
        .oe     (oe_q),
        .outv   (out_q),
        .alt_out(alt_out),
        .alt_oe (alt_oe),
        .pad_out(pad_out),
        .pad_oe (pad_oe)
    );

    assign irq = |(pend & ~mask_q);

    // R7
    unmask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_UNMASK) |=> ((mask_q & $past(wd)) == '0));
    // R7
    setmask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_SETMSK) |=> ((mask_q & $past(wd)) == $past(wd)));
    // R7
    mask_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == OFS_MASK) |=> (mask_q == $past(mask_q)));
    // R3
    input_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & dir_q & ~byp_q) == '0));
    // R12
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (($past(pend) != pend) || ($past(mask_q) != mask_q)));
endmodule

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/100ps
module tb_gpio_ctrl;
    localparam int NP = 12;
    localparam logic [NP-1:0] FULL = {NP{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe, alt_out = '0, alt_oe = '0;
    logic          irq;

    int checks = 0, errors = 0;

    gpio_ctrl #(.NPIN(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic rdchk(input logic [5:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        chk(d === exp, tag, d, exp);
    endtask

    // mode 0 level-high, 1 level-low, 2 rising, 3 falling, 4 both edges
    task automatic cfg(input int m);
        wr(6'h24, (m < 2) ? 32'(FULL) : 32'h0);
        wr(6'h28, (m == 0 || m == 2) ? 32'(FULL) : 32'h0);
        wr(6'h2C, (m == 4) ? 32'(FULL) : 32'h0);
    endtask

    function automatic logic [NP-1:0] exp_chg(input int m, input logic [NP-1:0] a, input logic [NP-1:0] b);
        case (m)
            0: return a | b;
            1: return ~a | ~b;
            2: return ~a & b;
            3: return a & ~b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [NP-1:0] steady(input int m, input logic [NP-1:0] b);
        case (m)
            0: return b;
            1: return ~b;
            default: return '0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [NP-1:0] pa [3];
        logic [NP-1:0] pb [3];
        pa[0] = '0;           pb[0] = FULL;
        pa[1] = FULL;         pb[1] = '0;
        pa[2] = 12'hA5C;      pb[2] = 12'h3C6;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rdchk(6'h00, 32'h0, "R1 bypass");
        rdchk(6'h04, 32'(FULL), "R1 dir");
        rdchk(6'h08, 32'h0, "R1 oe");
        rdchk(6'h0C, 32'h0, "R1 out");
        rdchk(6'h14, 32'(FULL), "R1 mask");
        rdchk(6'h20, 32'h0, "R1 pend");
        rdchk(6'h24, 32'h0, "R1 type");
        rdchk(6'h28, 32'h0, "R1 pol");
        rdchk(6'h2C, 32'h0, "R1 both");
        chk(irq === 1'b0, "R1 irq", 32'(irq), 32'h0);
        // R14 unlisted offsets
        rdchk(6'h30, 32'h0, "R14 unlisted 0x30");
        rdchk(6'h18, 32'h0, "R14 strobe 0x18 reads zero");

        // R2 / R5 upper bits and readback
        wr(6'h0C, 32'hFFFF_FFFF);
        rdchk(6'h0C, 32'(FULL), "R2 R5 out upper bits zero");
        wr(6'h0C, 32'h0000_0A53);
        rdchk(6'h0C, 32'h0000_0A53, "R5 out readback");
        wr(6'h18, 32'hFFFF_F000);
        rdchk(6'h14, 32'(FULL), "R2 unmask of absent pins ignored");
        // R7 mask offset is read-only
        wr(6'h14, 32'h0);
        rdchk(6'h14, 32'(FULL), "R7 mask write ignored");
        wr(6'h18, 32'h0000_0F0F);
        rdchk(6'h14, 32'h0000_00F0, "R7 unmask");
        wr(6'h1C, 32'h0000_0003);
        rdchk(6'h14, 32'h0000_00F3, "R7 setmask");
        // R14 direction / oe offsets
        wr(6'h04, 32'h0000_0123);
        rdchk(6'h04, 32'h0000_0123, "R14 dir at 0x04");
        wr(6'h08, 32'h0000_0456);
        rdchk(6'h08, 32'h0000_0456, "R14 oe at 0x08");

        // R3 R4 R5 pad mux sweep
        for (int p = 0; p < 24; p++) begin
            logic [31:0] h;
            logic [NP-1:0] dv, ov, bv, vv, eo, eoe;
            h  = p * 32'h9E37_79B1 + 32'h1234_5678;
            dv = h[11:0]; ov = h[23:12]; bv = h[31:20] ^ h[7:0];
            vv = h[17:6];
            alt_out = ~h[11:0]; alt_oe = h[19:8];
            wr(6'h04, 32'(dv)); wr(6'h08, 32'(ov));
            wr(6'h00, 32'(bv)); wr(6'h0C, 32'(vv));
            eo  = (bv & alt_out) | (~bv & vv);
            eoe = (bv & alt_oe) | (~bv & ov & ~dv);
            #1;
            chk(pad_out === eo, "R4 R5 pad_out", 32'(pad_out), 32'(eo));
            chk(pad_oe === eoe, "R3 R4 pad_oe", 32'(pad_oe), 32'(eoe));
        end
        wr(6'h00, 32'h0);
        wr(6'h04, 32'(FULL));

        // R6 two-edge synchronisation
        @(negedge clk) pad_in = 12'h5A3;
        rdchk(6'h10, 32'h0, "R6 input not yet visible after one edge");
        rdchk(6'h10, 32'h0000_05A3, "R6 input visible after two edges");
        @(negedge clk) pad_in = '0;
        repeat (3) @(negedge clk);

        // interrupt mode sweep, all pins unmasked
        wr(6'h18, 32'(FULL));
        for (int m = 0; m < 5; m++) begin
            for (int k = 0; k < 3; k++) begin
                logic [NP-1:0] ex;
                @(negedge clk) pad_in = pa[k];
                cfg(m);
                repeat (5) @(negedge clk);
                rd(6'h20, d);
                repeat (5) @(negedge clk);
                ex = steady(m, pa[k]);
                rdchk(6'h20, 32'(ex), (m < 2) ? "R9 level steady" : "R10 R11 no edge no event");
                @(negedge clk) pad_in = pb[k];
                repeat (6) @(negedge clk);
                ex = exp_chg(m, pa[k], pb[k]);
                #1;
                chk(irq === (ex != '0), "R12 irq follows unmasked pending", 32'(irq), 32'(ex != '0));
                rdchk(6'h20, 32'(ex), (m < 2) ? "R8 R9 level pending" :
                                      (m < 4) ? "R8 R10 edge pending" : "R8 R11 both-edge pending");
                ex = steady(m, pb[k]);
                rdchk(6'h20, 32'(ex), (m < 2) ? "R9 level re-set after read" : "R8 edge cleared by read");
            end
        end

        // R13 latched while masked; R12 gating by mask
        cfg(2);
        @(negedge clk) pad_in = '0;
        repeat (4) @(negedge clk);
        wr(6'h1C, 32'(FULL));
        rd(6'h20, d);
        @(negedge clk) pad_in = 12'h0F0;
        repeat (6) @(negedge clk);
        chk(irq === 1'b0, "R12 masked pending gives no irq", 32'(irq), 32'h0);
        wr(6'h18, 32'h0000_0F00);
        #1 chk(irq === 1'b0, "R12 unmask of idle pins gives no irq", 32'(irq), 32'h0);
        wr(6'h18, 32'h0000_0010);
        #1 chk(irq === 1'b1, "R12 unmask of pending pin raises irq", 32'(irq), 32'h1);
        rdchk(6'h20, 32'h0000_00F0, "R13 pending kept while masked");
        #1 chk(irq === 1'b0, "R8 R12 irq drops after read", 32'(irq), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule